// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block holds the base mode word of a DDR SDRAM controller and turns each accepted READ or WRITE command into the column addresses of one burst, one per clock. A load strobe with the bank-select bits at zero writes the base mode word. From that word the block decodes three things: a burst of 2, 4 or 8 beats, sequential or interleaved beat order, and a read latency counted in half clocks. Loads aimed at any other bank value target the extended register, and this block leaves its stored word unchanged for them.

Each burst stays inside an aligned block of columns as large as the burst. The column bits above the block stay fixed. The low bits start at the requested column and wrap at the block edge. In sequential order they count up modulo the burst length. In interleaved order they are the start bits XORed with the beat number. A burst takes its length and order from the mode word at the moment its command is accepted. A new command may be given on the last beat, and its burst then follows with no idle cycle. Three flags show when the stored word holds a reserved code. A command given while the burst-length code is reserved is refused.

Top module: `ddr_burst_colgen`

## Requirements
- R1: Mode word bits [2:0] set the burst length: 001 gives 2, 010 gives 4, 011 gives 8. Any other code sets `bl_rsvd`.
- R2: Mode word bit 3 sets the beat order: 0 is sequential and 1 is interleaved.
- R3: Mode word bits [6:4] set `lat_x2`, the read latency in half clocks: 010 gives 4 and 110 gives 5. Any other code sets `lat_rsvd` and drives `lat_x2` to 0.
- R4: A load with `mode_bank` other than 00 leaves the stored word, and every output decoded from it, unchanged.
- R5: Bits [MODE_W-1:7] form the operating field. The field is normal when all its bits are 0, or when only word bit 8 is 1. Any other value sets `op_rsvd`.
- R6: During a burst, column bits above bit 0, 1 or 2 (for lengths 2, 4 or 8) hold the value of the starting column.
- R7: Beat 0 carries the starting column and appears in the cycle after the command is accepted. Each later beat follows one clock after the one before, with no gap.
- R8: In sequential order, beat n has low bits (start + n) mod length. In interleaved order, beat n has low bits start XOR n.
- R9: `beat_last` is high on the final beat only. A command given on the final beat starts a new burst in the next cycle. A command given before the final beat is ignored.
- R10: After reset the word selects length 2, sequential order and `lat_x2` = 4. All reserved flags are low and no beat is valid.
- R11: A command accepted while `bl_rsvd` is high gives no beats, and it raises `cmd_rej` for one cycle in the slot where beat 0 would have appeared.
- R12: A burst keeps the length and order that were in force when its command was accepted, even if the mode word is loaded again during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode-register load strobe |
| mode_bank | input | 2 | Bank-select bits of the load; 00 selects the base register |
| mode_word | input | MODE_W | Address bits carrying the mode word |
| cmd_valid | input | 1 | READ or WRITE command strobe |
| cmd_col | input | COL_W | Starting column of the command |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | The current beat is the last of its burst |
| cmd_rej | output | 1 | A command was refused because the length code is reserved |
| lat_x2 | output | 3 | Decoded read latency in half clocks (0 when reserved) |
| bl_rsvd | output | 1 | Stored burst-length code is reserved |
| lat_rsvd | output | 1 | Stored latency code is reserved |
| op_rsvd | output | 1 | Stored operating field is reserved |

## Verification
The properties assume that `mode_bank`, `mode_load`, `cmd_valid` and `cmd_col` are at known levels in every cycle after reset. The chaining property also assumes that `cmd_col` is valid in the same cycle as `cmd_valid`. The bench changes every input only at the falling clock edge and holds each strobe for exactly one cycle. It returns strobes to 0 between scenarios and holds the bank bits at a defined value even when no load is pending. Commands are given only at times the scenario chooses on purpose: while idle, on a final beat, or in the middle of a burst to show that it is ignored.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam logic [2:0] BL_CODE_2 = 3'b001;
    localparam logic [2:0] BL_CODE_4 = 3'b010;
    localparam logic [2:0] BL_CODE_8 = 3'b011;
    localparam logic [2:0] LAT_CODE_2   = 3'b010;
    localparam logic [2:0] LAT_CODE_2P5 = 3'b110;

    // Low beat bits within the aligned block: wrap-add or XOR, masked to the block size.
    function automatic logic [2:0] beat_low(input logic [2:0] start,
                                            input logic [2:0] n,
                                            input logic [2:0] mask,
                                            input logic       ilv);
        logic [2:0] r;
        r = ilv ? (start ^ n) : (start + n);
        return r & mask;
    endfunction

endpackage

// File: rtl/colgen_mode.sv
module colgen_mode #(
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        bank,
    input  logic [MODE_W-1:0] word,
    output logic [2:0]        bl_mask,
    output logic              ilv,
    output logic              bl_rsvd,
    output logic [2:0]        lat_x2,
    output logic              lat_rsvd,
    output logic              op_rsvd
);
    import colgen_pkg::*;

    localparam int OP_W = MODE_W - 7;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [2:0]      cl;
        logic            bt;
        logic [2:0]      bl;
    } mr_t;

    mr_t mr_d, mr_q;

    always_comb begin
        mr_d = mr_q;
        if (load && (bank == 2'b00)) begin
            mr_d.bl = word[2:0];
            mr_d.bt = word[3];
            mr_d.cl = word[6:4];
            mr_d.op = word[MODE_W-1:7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_q.bl <= BL_CODE_2;
            mr_q.bt <= 1'b0;
            mr_q.cl <= LAT_CODE_2;
            mr_q.op <= '0;
        end else begin
            mr_q <= mr_d;
        end
    end

    always_comb begin
        bl_rsvd = 1'b0;
        unique case (mr_q.bl)
            BL_CODE_2: bl_mask = 3'd1;
            BL_CODE_4: bl_mask = 3'd3;
            BL_CODE_8: bl_mask = 3'd7;
            default: begin
                bl_mask = 3'd0;
                bl_rsvd = 1'b1;
            end
        endcase
    end

    always_comb begin
        lat_rsvd = 1'b0;
        unique case (mr_q.cl)
            LAT_CODE_2:   lat_x2 = 3'd4;
            LAT_CODE_2P5: lat_x2 = 3'd5;
            default: begin
                lat_x2   = 3'd0;
                lat_rsvd = 1'b1;
            end
        endcase
    end

    assign ilv     = mr_q.bt;
    assign op_rsvd = !((mr_q.op == '0) || (mr_q.op == OP_W'(2)));

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       bl_mask,
    input  logic             ilv,
    input  logic             bl_rsvd,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             cmd_rej
);
    import colgen_pkg::*;

    localparam int HI_W = COL_W - 3;

    typedef struct packed {
        logic             active;
        logic             last;
        logic             rej;
        logic             ilv;
        logic [2:0]       idx;
        logic [2:0]       mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] col;
    } seq_t;

    seq_t s_d, s_q;

    logic             take;
    logic [2:0]       nxt_idx;
    logic [COL_W-1:0] keep_mask;

    always_comb begin
        s_d       = s_q;
        s_d.rej   = 1'b0;
        take      = cmd_valid && (!s_q.active || s_q.last);
        nxt_idx   = s_q.idx + 3'd1;
        keep_mask = ~{{HI_W{1'b0}}, s_q.mask};
        if (take) begin
            if (bl_rsvd) begin
                s_d.active = 1'b0;
                s_d.last   = 1'b0;
                s_d.rej    = 1'b1;
            end else begin
                s_d.active = 1'b1;
                s_d.last   = 1'b0;
                s_d.idx    = 3'd0;
                s_d.mask   = bl_mask;
                s_d.ilv    = ilv;
                s_d.base   = cmd_col;
                s_d.col    = cmd_col;
            end
        end else if (s_q.active) begin
            if (s_q.last) begin
                s_d.active = 1'b0;
                s_d.last   = 1'b0;
            end else begin
                s_d.idx  = nxt_idx;
                s_d.col  = (s_q.base & keep_mask) |
                           {{HI_W{1'b0}}, beat_low(s_q.base[2:0], nxt_idx, s_q.mask, s_q.ilv)};
                s_d.last = (nxt_idx == s_q.mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign beat_col   = s_q.col;
    assign beat_valid = s_q.active;
    assign beat_last  = s_q.last;
    assign cmd_rej    = s_q.rej;

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen #(
    parameter int COL_W  = 10,
    parameter int MODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [1:0]        mode_bank,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              cmd_valid,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              cmd_rej,
    output logic [2:0]        lat_x2,
    output logic              bl_rsvd,
    output logic              lat_rsvd,
    output logic              op_rsvd
);
    logic [2:0] bl_mask;
    logic       ilv;

    colgen_mode #(.MODE_W(MODE_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .bank     (mode_bank),
        .word     (mode_word),
        .bl_mask  (bl_mask),
        .ilv      (ilv),
        .bl_rsvd  (bl_rsvd),
        .lat_x2   (lat_x2),
        .lat_rsvd (lat_rsvd),
        .op_rsvd  (op_rsvd)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_col    (cmd_col),
        .bl_mask    (bl_mask),
        .ilv        (ilv),
        .bl_rsvd    (bl_rsvd),
        .beat_col   (beat_col),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .cmd_rej    (cmd_rej)
    );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
    parameter int COL_W  = 10,
    parameter int MODE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_load,
    input logic [1:0]        mode_bank,
    input logic [MODE_W-1:0] mode_word,
    input logic              cmd_valid,
    input logic [COL_W-1:0]  cmd_col,
    input logic [COL_W-1:0]  beat_col,
    input logic              beat_valid,
    input logic              beat_last,
    input logic              cmd_rej,
    input logic [2:0]        lat_x2,
    input logic              bl_rsvd,
    input logic              lat_rsvd,
    input logic              op_rsvd
);
    logic unused_w;
    assign unused_w = ^mode_word;

    p_lat_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_rsvd |-> (lat_x2 == 3'd4 || lat_x2 == 3'd5));

    p_ext_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && mode_bank != 2'b00) |=>
            ($stable(lat_x2) && $stable(bl_rsvd) && $stable(lat_rsvd) && $stable(op_rsvd)));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));

    p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> beat_valid);

    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    p_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && cmd_valid && !bl_rsvd) |=> (beat_valid && !beat_last && beat_col == $past(cmd_col)));

    p_rej_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rej |-> !beat_valid);

endmodule

bind ddr_burst_colgen colgen_checker #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_load  (mode_load),
    .mode_bank  (mode_bank),
    .mode_word  (mode_word),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .beat_col   (beat_col),
    .beat_valid (beat_valid),
    .beat_last  (beat_last),
    .cmd_rej    (cmd_rej),
    .lat_x2     (lat_x2),
    .bl_rsvd    (bl_rsvd),
    .lat_rsvd   (lat_rsvd),
    .op_rsvd    (op_rsvd)
);

// File: tb/ddr_burst_colgen_test.sv
`timescale 1ns/1ps
module ddr_burst_colgen_test;
    localparam int COL_W  = 10;
    localparam int MODE_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_load = 1'b0;
    logic [1:0]        mode_bank = 2'b00;
    logic [MODE_W-1:0] mode_word = '0;
    logic              cmd_valid = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [COL_W-1:0]  beat_col;
    logic              beat_valid, beat_last, cmd_rej, bl_rsvd, lat_rsvd, op_rsvd;
    logic [2:0]        lat_x2;

    int checks = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ddr_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bank(mode_bank),
        .mode_word(mode_word), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
        .beat_col(beat_col), .beat_valid(beat_valid), .beat_last(beat_last),
        .cmd_rej(cmd_rej), .lat_x2(lat_x2), .bl_rsvd(bl_rsvd),
        .lat_rsvd(lat_rsvd), .op_rsvd(op_rsvd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MODE_W-1:0] mw(input int op, input int lat, input int bt, input int bl);
        return MODE_W'((op << 7) | (lat << 4) | (bt << 3) | bl);
    endfunction

    function automatic int exp_col(input int start, input int n, input int bl, input bit ilv);
        int lo;
        lo = start % bl;
        return (start - lo) + (ilv ? (lo ^ n) : ((lo + n) % bl));
    endfunction

    task automatic load_mode(input logic [1:0] bank, input logic [MODE_W-1:0] w);
        mode_load = 1'b1; mode_bank = bank; mode_word = w;
        @(negedge clk);
        mode_load = 1'b0; mode_bank = 2'b00;
    endtask

    task automatic burst(input int col, input int bl, input bit ilv, input string req);
        cmd_valid = 1'b1; cmd_col = COL_W'(col);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int n = 0; n < bl; n++) begin
            chk(beat_valid && beat_col == COL_W'(exp_col(col, n, bl, ilv)) && beat_last == (n == bl - 1),
                req, int'(beat_col), exp_col(col, n, bl, ilv));
            @(negedge clk);
        end
        chk(!beat_valid, req, int'(beat_valid), 0);
    endtask

    task automatic t_reset;
        chk(!beat_valid && !beat_last && !cmd_rej, "R10", int'(beat_valid), 0);
        chk(lat_x2 == 3'd4 && !bl_rsvd && !lat_rsvd && !op_rsvd, "R10", int'(lat_x2), 4);
        burst('h013, 2, 1'b0, "R10");
    endtask

    task automatic t_orders;
        load_mode(2'b00, mw(0, 6, 0, 3));
        chk(lat_x2 == 3'd5 && !lat_rsvd, "R3", int'(lat_x2), 5);
        chk(!bl_rsvd, "R1", int'(bl_rsvd), 0);
        burst('h2D5, 8, 1'b0, "R8");
        load_mode(2'b00, mw(0, 2, 1, 3));
        chk(lat_x2 == 3'd4, "R3", int'(lat_x2), 4);
        burst('h2D5, 8, 1'b1, "R2");
        burst('h3FE, 8, 1'b1, "R8");
        load_mode(2'b00, mw(0, 2, 0, 2));
        burst('h0B7, 4, 1'b0, "R6");
        load_mode(2'b00, mw(0, 2, 1, 2));
        burst('h0B6, 4, 1'b1, "R6");
    endtask

    task automatic t_reserved;
        load_mode(2'b00, mw(0, 3, 0, 1));
        chk(lat_rsvd && lat_x2 == 3'd0, "R3", int'(lat_x2), 0);
        load_mode(2'b00, mw(2, 2, 0, 1));
        chk(!op_rsvd, "R5", int'(op_rsvd), 0);
        load_mode(2'b00, mw(4, 2, 0, 1));
        chk(op_rsvd, "R5", int'(op_rsvd), 1);
        load_mode(2'b00, mw(1, 2, 0, 1));
        chk(op_rsvd, "R5", int'(op_rsvd), 1);
        load_mode(2'b00, mw(0, 2, 0, 4));
        chk(bl_rsvd, "R1", int'(bl_rsvd), 1);
        load_mode(2'b00, mw(0, 2, 0, 0));
        chk(bl_rsvd, "R1", int'(bl_rsvd), 1);
        cmd_valid = 1'b1; cmd_col = 'h044;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!beat_valid && cmd_rej, "R11", int'(beat_valid), 0);
        @(negedge clk);
        chk(!beat_valid && !cmd_rej, "R11", int'(cmd_rej), 0);
    endtask

    task automatic t_ext;
        load_mode(2'b00, mw(0, 2, 0, 2));
        load_mode(2'b01, mw(0, 6, 1, 3));
        load_mode(2'b10, mw(5, 3, 1, 0));
        load_mode(2'b11, mw(0, 6, 1, 3));
        chk(lat_x2 == 3'd4 && !bl_rsvd && !lat_rsvd && !op_rsvd, "R4", int'(lat_x2), 4);
        burst('h121, 4, 1'b0, "R4");
    endtask

    task automatic t_chain;
        load_mode(2'b00, mw(0, 2, 0, 2));
        cmd_valid = 1'b1; cmd_col = 'h052;
        @(negedge clk);
        chk(beat_valid && beat_col == 'h052, "R7", int'(beat_col), 'h052);
        cmd_col = 'h3C0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(beat_valid && beat_col == 'h053 && !beat_last, "R9", int'(beat_col), 'h053);
        @(negedge clk);
        chk(beat_col == 'h050, "R8", int'(beat_col), 'h050);
        @(negedge clk);
        chk(beat_last && beat_col == 'h051, "R9", int'(beat_col), 'h051);
        cmd_valid = 1'b1; cmd_col = 'h1E7;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(beat_valid && !beat_last && beat_col == 'h1E7, "R9", int'(beat_col), 'h1E7);
        for (int n = 1; n < 4; n++) begin
            @(negedge clk);
            chk(beat_valid && beat_col == COL_W'(exp_col('h1E7, n, 4, 1'b0)), "R7",
                int'(beat_col), exp_col('h1E7, n, 4, 1'b0));
        end
        @(negedge clk);
        chk(!beat_valid, "R9", int'(beat_valid), 0);
    endtask

    task automatic t_mid_load;
        load_mode(2'b00, mw(0, 2, 1, 3));
        cmd_valid = 1'b1; cmd_col = 'h10B;
        @(negedge clk);
        cmd_valid = 1'b0;
        mode_load = 1'b1; mode_bank = 2'b00; mode_word = mw(0, 2, 0, 1);
        for (int n = 0; n < 8; n++) begin
            chk(beat_valid && beat_col == COL_W'(exp_col('h10B, n, 8, 1'b1)) && beat_last == (n == 7),
                "R12", int'(beat_col), exp_col('h10B, n, 8, 1'b1));
            @(negedge clk);
            mode_load = 1'b0;
        end
        chk(!beat_valid, "R12", int'(beat_valid), 0);
        burst('h10B, 2, 1'b0, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_orders();
        t_reserved();
        t_ext();
        t_chain();
        t_mid_load();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule